// File: doc/BRIEF.md
# Power-Management Event Controller

This block holds the fixed power-management registers of a platform controller. A free-running timer advances once for each cycle in which the tick input is high. An event status register collects wake events and timer overflows. An enable register selects which of those events drive the level-sensitive system control interrupt. A control register holds the interrupt-mode enable and accepts suspend requests.

A separate command port takes one byte at a time. Two command values switch interrupt mode on and off. A write to this port can also raise a system management interrupt pulse, but only when the configuration input allows it.

Software reaches the registers through a simple port that carries a 6-bit byte offset, 16-bit write data, a write strobe and a read strobe. Read data is registered and is valid in the cycle after the read strobe. When the I/O enable input is low, the whole register window is switched off.

Top module: `pm_evt_ctrl`

## Requirements
- R1: The timer is TMR_W bits wide (default 24). It increments by one, wrapping at the top, on each clock edge where `tick` is high. A read at offset 0x08 returns the count, zero-extended to 32 bits.
- R2: Status bit 0 becomes 1 on the edge where a tick moves the count onto a multiple of 2^OVF_BIT (default 0x800000). This includes the wrap to zero. After software clears the bit, it sets again only at the next such multiple.
- R3: A high `wake_evt[2]`, `wake_evt[1]` or `wake_evt[0]` sets status bit 10, 8 or 5 respectively. Status reads at offset 0x00, and only bits 10, 8, 5 and 0 can ever read as 1.
- R4: A write to offset 0x00 clears every status bit written as 1 and leaves the others. An event that arrives in the same cycle wins over the clear.
- R5: A write to offset 0x02 stores all 16 data bits into the enable register, which reads back at 0x02.
- R6: `sci` is high exactly when (status AND enable) has bit 10, 8, 5 or 0 set.
- R7: A write to offset 0x04 stores every data bit except bit 13 into the control register. Bit 13 always reads 0 at offset 0x04.
- R8: A control write with bit 13 = 1 and bits 12:10 = 0 gives a one-cycle `soft_off` pulse in the next cycle. Any other suspend type gives no pulse.
- R9: Command byte 0xF1 sets control bit 0 and 0xF0 clears it. Other bytes leave the bit alone. When a control write lands in the same cycle, the command is applied after it.
- R10: `smi` pulses high for one cycle after each command write made while `smi_en_cfg` is high. It stays low otherwise.
- R11: While `io_en` is low, register writes change nothing (no state and no `soft_off`), and reads return 0xFFFFFFFF.
- R12: After reset, the timer, status, enable, control and read data are all zero. Offsets other than 0x00, 0x02, 0x04 and 0x08 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | Register window enable |
| smi_en_cfg | input | 1 | Allows command writes to raise SMI |
| tick | input | 1 | Timer advance strobe |
| wake_evt | input | 3 | Event pulses: [2] RTC, [1] power button, [0] global |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| smi_cmd_wr | input | 1 | Command port write strobe |
| smi_cmd_data | input | 8 | Command byte |
| sci | output | 1 | Level interrupt |
| smi | output | 1 | One-cycle management interrupt pulse |
| soft_off | output | 1 | One-cycle soft power-off request |

## Verification
Directed sequences cover four things. They walk the timer up to one count below the overflow boundary and then across it, which shows that the flag appears on the boundary tick and no earlier. They hit status with a clear and an event in the same cycle, which separates set-wins from clear-wins. They write the control register with different suspend types, which separates a type-0 suspend from the other types. They drive every command value class with the configuration bit high and low.

Seeded random traffic then mixes ticks, events, writes, reads, commands and a sometimes-low I/O enable. A cycle-level bench model predicts every read, every interrupt level and every pulse. Mismatches under this mix expose ordering faults such as a command and a control write in the same cycle, and any leak of writes through a disabled window.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned RD_W   = 32;

  localparam logic [ADDR_W-1:0] OFS_STS = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_EN  = 6'h02;
  localparam logic [ADDR_W-1:0] OFS_CTL = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_TMR = 6'h08;

  localparam int unsigned BIT_TOVF  = 0;
  localparam int unsigned BIT_GBL   = 5;
  localparam int unsigned BIT_PWR   = 8;
  localparam int unsigned BIT_RTC   = 10;
  localparam int unsigned BIT_SUSGO = 13;
  localparam int unsigned BIT_SCIEN = 0;
  localparam int unsigned SUSTYP_LO = 10;

  localparam int unsigned N_WAKE = 3;
  // wake_evt index -> status bit position
  localparam int unsigned WAKE_POS [N_WAKE] = '{BIT_GBL, BIT_PWR, BIT_RTC};

  localparam logic [DATA_W-1:0] EVT_MASK =
    (DATA_W'(1) << BIT_RTC) | (DATA_W'(1) << BIT_PWR) |
    (DATA_W'(1) << BIT_GBL) | (DATA_W'(1) << BIT_TOVF);

  localparam logic [7:0] CMD_ACPI_ON  = 8'hF1;
  localparam logic [7:0] CMD_ACPI_OFF = 8'hF0;
endpackage

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int unsigned TMR_W   = 24,
  parameter int unsigned OVF_BIT = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [TMR_W-1:0] cnt,
  output logic             ovf_evt
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  // next value lands on a multiple of 2^OVF_BIT
  assign ovf_evt = tick & (&cnt_q[OVF_BIT-1:0]);
  assign cnt     = cnt_q;
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sts,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic              ovf_evt,
  output logic [DATA_W-1:0] sts,
  output logic [DATA_W-1:0] en,
  output logic              sci
);
  logic [DATA_W-1:0] sts_q, sts_d, en_q, en_d, set_v, clr_v;
  logic [N_WAKE-1:0][DATA_W-1:0] wake_v;

  for (genvar g = 0; g < N_WAKE; g++) begin : g_wake
    assign wake_v[g] = wake_evt[g] ? (DATA_W'(1) << WAKE_POS[g]) : '0;
  end

  always_comb begin
    set_v = ovf_evt ? (DATA_W'(1) << BIT_TOVF) : '0;
    for (int i = 0; i < N_WAKE; i++) set_v |= wake_v[i];
    clr_v = wr_sts ? wdata : '0;
    sts_d = ((sts_q & ~clr_v) | set_v) & EVT_MASK;
    en_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  assign sts = sts_q;
  assign en  = en_q;
  assign sci = |(sts_q & en_q & EVT_MASK);
endmodule

// File: rtl/pm_ctl.sv
module pm_ctl
  import pm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_data,
  input  logic              smi_cfg,
  output logic [DATA_W-1:0] ctl,
  output logic              smi,
  output logic              soft_off
);
  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic              smi_q, smi_d, off_q, off_d;
  logic              ctl_ce;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d            = wdata;
      ctl_d[BIT_SUSGO] = 1'b0;
    end
    if (cmd_wr && cmd_data == CMD_ACPI_ON)  ctl_d[BIT_SCIEN] = 1'b1;
    if (cmd_wr && cmd_data == CMD_ACPI_OFF) ctl_d[BIT_SCIEN] = 1'b0;
    ctl_ce = wr_ctl | cmd_wr;
    smi_d  = cmd_wr & smi_cfg;
    off_d  = wr_ctl & wdata[BIT_SUSGO] & (wdata[SUSTYP_LO+2:SUSTYP_LO] == 3'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_q <= 1'b0;
      off_q <= 1'b0;
    end else begin
      smi_q <= smi_d;
      off_q <= off_d;
    end
  end

  assign ctl      = ctl_q;
  assign smi      = smi_q;
  assign soft_off = off_q;
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W   = 24,
  parameter int unsigned OVF_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              smi_en_cfg,
  input  logic              tick,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [RD_W-1:0]   reg_rdata,
  input  logic              smi_cmd_wr,
  input  logic [7:0]        smi_cmd_data,
  output logic              sci,
  output logic              smi,
  output logic              soft_off
);
  localparam int unsigned TPAD = RD_W - TMR_W;
  localparam int unsigned DPAD = RD_W - DATA_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  logic              wr_sts, wr_en, wr_ctl, ovf_evt;
  logic [TMR_W-1:0]  tmr_cnt;
  logic [DATA_W-1:0] sts_q, en_q, ctl_q;
  logic [RD_W-1:0]   rdata_q, rdata_d;

  assign wr_sts = reg_wr & io_en & (reg_addr == OFS_STS);
  assign wr_en  = reg_wr & io_en & (reg_addr == OFS_EN);
  assign wr_ctl = reg_wr & io_en & (reg_addr == OFS_CTL);

  pm_tmr #(.TMR_W(TMR_W), .OVF_BIT(OVF_BIT)) u_tmr (
    .clk(clk), .rst_n(rst_n_sync), .tick(tick), .cnt(tmr_cnt), .ovf_evt(ovf_evt)
  );

  pm_evt_regs u_regs (
    .clk(clk), .rst_n(rst_n_sync), .wr_sts(wr_sts), .wr_en(wr_en), .wdata(reg_wdata),
    .wake_evt(wake_evt), .ovf_evt(ovf_evt), .sts(sts_q), .en(en_q), .sci(sci)
  );

  pm_ctl u_ctl (
    .clk(clk), .rst_n(rst_n_sync), .wr_ctl(wr_ctl), .wdata(reg_wdata),
    .cmd_wr(smi_cmd_wr), .cmd_data(smi_cmd_data), .smi_cfg(smi_en_cfg),
    .ctl(ctl_q), .smi(smi), .soft_off(soft_off)
  );

  always_comb begin
    rdata_d = '0;
    if (!io_en) rdata_d = '1;
    else begin
      case (reg_addr)
        OFS_STS: rdata_d = {{DPAD{1'b0}}, sts_q};
        OFS_EN:  rdata_d = {{DPAD{1'b0}}, en_q};
        OFS_CTL: rdata_d = {{DPAD{1'b0}}, ctl_q};
        OFS_TMR: rdata_d = {{TPAD{1'b0}}, tmr_cnt};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  rdata_q <= '0;
    else if (reg_rd)  rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/pm_evt_ctrl_chk.sv
module pm_evt_ctrl_chk
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W   = 24,
  parameter int unsigned OVF_BIT = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_en,
  input logic              smi_en_cfg,
  input logic              tick,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [RD_W-1:0]   reg_rdata,
  input logic              smi_cmd_wr,
  input logic              sci,
  input logic              smi,
  input logic              soft_off,
  input logic [TMR_W-1:0]  tmr_cnt,
  input logic [DATA_W-1:0] sts_q
);
  a_r1_tmr_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tmr_cnt == $past(tmr_cnt) + TMR_W'(1));

  a_r1_tmr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tmr_cnt));

  a_r2_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&tmr_cnt[OVF_BIT-1:0])) |=> sts_q[BIT_TOVF]);

  a_r6_sci_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && io_en && reg_addr == OFS_EN && reg_wdata == '0) |=> !sci);

  a_r8_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off |-> $past(reg_wr && io_en && reg_addr == OFS_CTL &&
                       reg_wdata[BIT_SUSGO] && reg_wdata[SUSTYP_LO+2:SUSTYP_LO] == 3'd0));

  a_r10_smi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> $past(smi_cmd_wr && smi_en_cfg));

  a_r11_dis_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !io_en) |=> reg_rdata == '1);
endmodule

bind pm_evt_ctrl pm_evt_ctrl_chk #(.TMR_W(TMR_W), .OVF_BIT(OVF_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .io_en(io_en), .smi_en_cfg(smi_en_cfg), .tick(tick),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .smi_cmd_wr(smi_cmd_wr), .sci(sci), .smi(smi),
  .soft_off(soft_off), .tmr_cnt(tmr_cnt), .sts_q(sts_q)
);

// File: tb/pm_evt_ctrl_bench.sv
module pm_evt_ctrl_bench;
  localparam int TW = 12;
  localparam int OB = 11;
  localparam logic [15:0] MASK = 16'h0521;

  logic        clk = 1'b0;
  logic        rst_n, io_en, smi_en_cfg, tick, reg_wr, reg_rd, smi_cmd_wr;
  logic [2:0]  wake_evt;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [7:0]  smi_cmd_data;
  logic [31:0] reg_rdata;
  logic        sci, smi, soft_off;

  always #5 clk = ~clk;

  pm_evt_ctrl #(.TMR_W(TW), .OVF_BIT(OB)) u_pm_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .smi_en_cfg(smi_en_cfg), .tick(tick),
    .wake_evt(wake_evt), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi_cmd_wr(smi_cmd_wr),
    .smi_cmd_data(smi_cmd_data), .sci(sci), .smi(smi), .soft_off(soft_off)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [TW-1:0] m_cnt;
  logic [15:0]   m_sts, m_en, m_ctl;
  logic [31:0]   m_rd;
  logic          m_smi, m_off;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_val(logic [5:0] a, logic ioe);
    if (!ioe) return 32'hFFFF_FFFF;
    case (a)
      6'h00: return {16'h0, m_sts};
      6'h02: return {16'h0, m_en};
      6'h04: return {16'h0, m_ctl};
      6'h08: return {{(32-TW){1'b0}}, m_cnt};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(logic [5:0] a, logic ioe);
    if (!ioe) return "R11";
    case (a)
      6'h00: return "R4";
      6'h02: return "R5";
      6'h04: return "R7";
      6'h08: return "R1";
      default: return "R12";
    endcase
  endfunction

  // one clock cycle: drive at negedge, update model at posedge, check at next negedge
  task automatic step(bit t, logic [2:0] ev, bit w, bit r, logic [5:0] a, logic [15:0] d,
                      bit cw, logic [7:0] cd, bit ioe, bit cfg, string tag);
    logic ovf;
    logic [15:0] clr, setv;
    string rt;
    tick = t; wake_evt = ev; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    smi_cmd_wr = cw; smi_cmd_data = cd; io_en = ioe; smi_en_cfg = cfg;
    @(posedge clk);
    rt = (tag != "") ? tag : rd_tag(a, ioe);
    if (r) m_rd = rd_val(a, ioe);
    ovf = t && (&m_cnt[OB-1:0]);
    if (t) m_cnt = m_cnt + 1'b1;
    clr  = (w && ioe && a == 6'h00) ? d : 16'h0;
    setv = {5'b0, ev[2], 1'b0, ev[1], 2'b0, ev[0], 4'b0, ovf};
    m_sts = ((m_sts & ~clr) | setv) & MASK;
    if (w && ioe && a == 6'h02) m_en = d;
    if (w && ioe && a == 6'h04) m_ctl = d & 16'hDFFF;
    if (cw && cd == 8'hF1) m_ctl[0] = 1'b1;
    if (cw && cd == 8'hF0) m_ctl[0] = 1'b0;
    m_smi = cw && cfg;
    m_off = w && ioe && a == 6'h04 && d[13] && d[12:10] == 3'd0;
    @(negedge clk);
    chk("R6", sci, |(m_sts & m_en & MASK));
    chk("R10", smi, m_smi);
    chk("R8", soft_off, m_off);
    if (r) chk(rt, reg_rdata, m_rd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "");
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, "");
  endtask
  task automatic wr(logic [5:0] a, logic [15:0] d);
    step(0, 0, 1, 0, a, d, 0, 0, 1, 0, "");
  endtask
  task automatic rd(logic [5:0] a, string tag);
    step(0, 0, 0, 1, a, 0, 0, 0, 1, 0, tag);
  endtask
  task automatic cmd(logic [7:0] c, bit cfg);
    step(0, 0, 0, 0, 0, 0, 1, c, 1, cfg, "");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; tick = 0; wake_evt = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0;
    reg_wdata = 0; smi_cmd_wr = 0; smi_cmd_data = 0; io_en = 1; smi_en_cfg = 0;
    m_cnt = 0; m_sts = 0; m_en = 0; m_ctl = 0; m_rd = 0; m_smi = 0; m_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3);
    // R12: reset values and an unmapped offset
    chk("R12", reg_rdata, 32'h0);
    rd(6'h00, "R12"); rd(6'h02, "R12"); rd(6'h04, "R12"); rd(6'h08, "R12"); rd(6'h0C, "R12");
    // R1: counting
    ticks(5);
    rd(6'h08, "R1");
    chk("R1", reg_rdata, 32'd5);
    // R2: one short of the boundary, then across it
    ticks((1 << OB) - 1 - 5);
    rd(6'h00, "R2");
    chk("R2", reg_rdata, 32'h0);
    ticks(1);
    rd(6'h00, "R2");
    chk("R2", reg_rdata, 32'h1);
    wr(6'h00, 16'h0001);
    rd(6'h00, "R4");
    chk("R4", reg_rdata, 32'h0);
    ticks(10);
    rd(6'h00, "R2");
    chk("R2", reg_rdata, 32'h0);
    // R3: wake events
    step(0, 3'b111, 0, 0, 0, 0, 0, 0, 1, 0, "");
    rd(6'h00, "R3");
    chk("R3", reg_rdata, 32'h0520);
    // R4: event in the same cycle as a clear wins
    step(0, 3'b100, 1, 0, 6'h00, 16'hFFFF, 0, 0, 1, 0, "");
    rd(6'h00, "R4");
    chk("R4", reg_rdata, 32'h0400);
    // R5/R6: enable matching bit drives sci, then mask off
    wr(6'h02, 16'h0400);
    chk("R6", sci, 1'b1);
    wr(6'h02, 16'hFBFF);
    chk("R6", sci, 1'b0);
    rd(6'h02, "R5");
    // R7/R8: suspend bit never stored, only type 0 powers off
    wr(6'h04, 16'hFFFF);
    chk("R8", soft_off, 1'b0);
    rd(6'h04, "R7");
    chk("R7", reg_rdata, 32'hDFFF);
    wr(6'h04, 16'h2000);
    chk("R8", soft_off, 1'b1);
    idle(1);
    chk("R8", soft_off, 1'b0);
    // R9/R10: command values
    cmd(8'hF1, 1);
    chk("R10", smi, 1'b1);
    rd(6'h04, "R9");
    chk("R9", reg_rdata, 32'h1);
    cmd(8'h55, 0);
    chk("R10", smi, 1'b0);
    rd(6'h04, "R9");
    cmd(8'hF0, 1);
    rd(6'h04, "R9");
    chk("R9", reg_rdata, 32'h0);
    // R9: command applied after a same-cycle control write
    step(0, 0, 1, 0, 6'h04, 16'h0000, 1, 8'hF1, 1, 0, "");
    rd(6'h04, "R9");
    // R11: disabled window
    step(0, 0, 1, 0, 6'h02, 16'hFFFF, 0, 0, 0, 0, "");
    step(0, 0, 1, 0, 6'h04, 16'h2000, 0, 0, 0, 0, "");
    chk("R11", soft_off, 1'b0);
    step(0, 0, 0, 1, 6'h02, 0, 0, 0, 0, 0, "R11");
    chk("R11", reg_rdata, 32'hFFFF_FFFF);
    rd(6'h02, "R11");
    chk("R11", reg_rdata, 32'h0000_FBFF);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      bit t, w, r, cw, ioe, cfg;
      logic [2:0] ev;
      logic [5:0] a;
      logic [7:0] cd;
      int k;
      t   = $urandom_range(0, 1);
      ev  = {($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0)};
      w   = ($urandom_range(0, 3) == 0);
      r   = ($urandom_range(0, 2) == 0);
      k   = $urandom_range(0, 5);
      a   = (k == 0) ? 6'h00 : (k == 1) ? 6'h02 : (k == 2) ? 6'h04 :
            (k == 3) ? 6'h08 : (k == 4) ? 6'h06 : 6'h0C;
      cw  = ($urandom_range(0, 7) == 0);
      k   = $urandom_range(0, 2);
      cd  = (k == 0) ? 8'hF0 : (k == 1) ? 8'hF1 : 8'($urandom_range(0, 255));
      ioe = ($urandom_range(0, 7) != 0);
      cfg = $urandom_range(0, 1);
      step(t, ev, w, r, a, 16'($urandom_range(0, 65535)), cw, cd, ioe, cfg, "");
    end
    finish_run();
  end
endmodule